// File: doc/BRIEF.md
# Incrementing Memory Fill Engine

This engine fills a run of consecutive memory words with a rising sequence of values. A caller hands it a seed value, a start address and a word count, then pulses `start`. The engine issues one write per word over a single-port write interface: the first word receives the seed, and each following word receives the previous value plus one at the next address. Writes wait for the memory's `mem_ready`, and only one write is outstanding at any time.

The operation can be interrupted. After any completed write that leaves words still to go, a pending `irq` stops the run; the engine then hands back the original seed and start address unchanged and raises `restart`, so the caller can reissue the whole operation later. A run that finishes normally returns zero in `a_out` and the address after the last written word in `b_out`. Both endings are marked by a one-cycle `done` pulse. A count of zero is taken as the full count range, 2^CNT_W words.

Top module: `seq_fill_engine`

## Requirements
- R1: `start` is accepted only while no run is active (`mem_we` low); a `start` pulse during a run changes neither the writes nor the results of that run.
- R2: The first write of a run carries `val_in` as data and the low ADDR_W bits of `addr_in` as address; the upper bits of `addr_in` do not affect any write address.
- R3: Each following write carries the previous data plus one modulo 2^DATA_W at the previous address plus one modulo 2^ADDR_W.
- R4: A count of N (1 to 2^CNT_W-1) produces exactly N writes when no interrupt occurs; a count of zero produces exactly 2^CNT_W writes.
- R5: A write is presented with `mem_we` high and is complete only on a cycle where `mem_ready` is high; while `mem_ready` is low the address and data stay unchanged.
- R6: On normal completion `done` is high for exactly one cycle, `mem_we` is low in that cycle, `restart` is low, `a_out` is zero and `b_out` holds the address after the last written word, wrapped to ADDR_W bits and zero-extended.
- R7: When `irq` is high on the cycle a write completes and words remain, the run stops after that write; `done` pulses, `restart` goes high, and `a_out`/`b_out` return the original `val_in` and the full, unmasked `addr_in`. `restart` stays high until the next accepted `start`.
- R8: At least one word is written before `irq` can stop a run: `irq` has no effect while the first write waits for `mem_ready`, and `irq` on the final write of a run does not prevent normal completion.
- R9: After reset `mem_we`, `done`, `restart`, `a_out` and `b_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the current seed inputs |
| irq | input | 1 | Interrupt pending; sampled when a write completes |
| val_in | input | DATA_W | Seed value for the first word |
| addr_in | input | DATA_W | Start address; only the low ADDR_W bits address memory |
| cnt_in | input | CNT_W | Number of words; zero means 2^CNT_W |
| mem_we | output | 1 | Write request, held until accepted |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the presented write this cycle |
| done | output | 1 | One-cycle pulse at the end of a run |
| restart | output | 1 | High when the last run was stopped by an interrupt |
| a_out | output | DATA_W | Zero on completion, original seed on interrupt |
| b_out | output | DATA_W | Next address on completion, original address on interrupt |

## Verification
The bench builds the engine with DATA_W=8, ADDR_W=6 and CNT_W=5, so a single run can wrap the value past 255, wrap the address past 63, and exercise the zero-count case with only 32 writes. With an 8-bit address input and a 6-bit memory address, the two ignored upper address bits can be set and shown to reach only the restored `b_out` after an interrupt. Runs are repeated with `mem_ready` held high and with it toggling every cycle to cover stalled writes, and interrupts are raised before the first write, mid-run and on the final word.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic {
    FE_IDLE = 1'b0,
    FE_RUN  = 1'b1
  } fe_state_t;
endpackage

// File: rtl/sfe_seq.sv
module sfe_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] seed_val,
  input  logic [ADDR_W-1:0] seed_addr,
  input  logic [CNT_W-1:0]  seed_cnt,
  output logic [DATA_W-1:0] cur_val,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_word
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_val  <= '0;
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_val  <= seed_val;
      cur_addr <= seed_addr;
      remain   <= seed_cnt;
    end else if (step) begin
      cur_val  <= cur_val + 1'b1;
      cur_addr <= cur_addr + 1'b1;
      remain   <= remain - 1'b1;
    end
  end

  // a zero count only reaches one after wrapping through the full range
  assign last_word = (remain == CNT_ONE);
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              irq,
  input  logic              mem_ready,
  input  logic              last_word,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] val_in,
  input  logic [DATA_W-1:0] addr_in,
  output logic              load,
  output logic              step,
  output logic              mem_we,
  output logic              done,
  output logic              restart,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out
);
  fe_state_t         state;
  logic [DATA_W-1:0] keep_a;
  logic [DATA_W-1:0] keep_b;
  logic [ADDR_W-1:0] next_addr;
  logic              fire;

  assign fire      = (state == FE_RUN) && mem_ready;
  assign load      = (state == FE_IDLE) && start;
  assign step      = fire;
  assign mem_we    = (state == FE_RUN);
  assign next_addr = cur_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FE_IDLE;
      done    <= 1'b0;
      restart <= 1'b0;
      a_out   <= '0;
      b_out   <= '0;
      keep_a  <= '0;
      keep_b  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        FE_IDLE: begin
          if (start) begin
            state   <= FE_RUN;
            restart <= 1'b0;
            keep_a  <= val_in;
            keep_b  <= addr_in;
          end
        end
        FE_RUN: begin
          if (mem_ready) begin
            if (last_word) begin
              state   <= FE_IDLE;
              done    <= 1'b1;
              restart <= 1'b0;
              a_out   <= '0;
              b_out   <= DATA_W'(next_addr);
            end else if (irq) begin
              state   <= FE_IDLE;
              done    <= 1'b1;
              restart <= 1'b1;
              a_out   <= keep_a;
              b_out   <= keep_b;
            end
          end
        end
        default: state <= FE_IDLE;
      endcase
    end
  end

  // R7: an abort is only ever caused by an interrupt seen on the completing write
  a_r7_abort_cause: assert property (@(posedge clk) disable iff (rst)
    (done && restart) |-> $past(irq));

  // R6: a finished run never leaves a nonzero value result
  a_r6_clean_finish: assert property (@(posedge clk) disable iff (rst)
    (done && !restart) |-> (a_out == '0));
endmodule

// File: rtl/seq_fill_engine.sv
module seq_fill_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              irq,
  input  logic [DATA_W-1:0] val_in,
  input  logic [DATA_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              restart,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out
);
  logic load, step, last_word;

  sfe_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .seed_val  (val_in),
    .seed_addr (addr_in[ADDR_W-1:0]),
    .seed_cnt  (cnt_in),
    .cur_val   (mem_wdata),
    .cur_addr  (mem_addr),
    .last_word (last_word)
  );

  sfe_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .irq       (irq),
    .mem_ready (mem_ready),
    .last_word (last_word),
    .cur_addr  (mem_addr),
    .val_in    (val_in),
    .addr_in   (addr_in),
    .load      (load),
    .step      (step),
    .mem_we    (mem_we),
    .done      (done),
    .restart   (restart),
    .a_out     (a_out),
    .b_out     (b_out)
  );

  // R3: back-to-back writes of one run rise by one in data
  a_r3_data_rises: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we && mem_ready)) |-> (mem_wdata == DATA_W'($past(mem_wdata) + 1'b1)));

  // R3: back-to-back writes of one run rise by one in address
  a_r3_addr_rises: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we && mem_ready)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R5: a stalled write keeps its address and data
  a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  // R6: the end-of-run pulse lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: no write is presented in the cycle that reports the end of a run
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);
endmodule

// File: tb/tb_seq_fill_engine.sv
`timescale 1ns/1ps
module tb_seq_fill_engine;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int CW = 5;
  localparam int FULL = 1 << CW;
  localparam int NV = 6;
  // {val[21:14], addr[13:6], cnt[5:1], stall[0]}
  localparam logic [21:0] VEC [NV] = '{
    {8'h10, 8'h05, 5'd3,  1'b0},
    {8'hFE, 8'h3E, 5'd4,  1'b0},
    {8'h20, 8'hC7, 5'd1,  1'b1},
    {8'h00, 8'h10, 5'd0,  1'b0},
    {8'h55, 8'h3F, 5'd5,  1'b1},
    {8'hFF, 8'h00, 5'd31, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic irq = 1'b0;
  logic [DW-1:0] val_in = '0;
  logic [DW-1:0] addr_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic mem_we, mem_ready, done, restart;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, a_out, b_out;
  logic stall = 1'b0;
  logic rdy_ph = 1'b0;

  int checks = 0;
  int fails = 0;
  int wcnt = 0;
  int base = 0;
  int nw = 0;
  logic [AW-1:0] log_a [256];
  logic [DW-1:0] log_d [256];

  always #5 clk = ~clk;
  assign mem_ready = stall ? rdy_ph : 1'b1;

  initial forever begin
    @(negedge clk);
    rdy_ph <= ~rdy_ph;
  end

  always @(posedge clk) begin
    if (!rst && mem_we && mem_ready) begin
      log_a[wcnt % 256] <= mem_addr;
      log_d[wcnt % 256] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
  end

  seq_fill_engine #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .irq(irq),
    .val_in(val_in), .addr_in(addr_in), .cnt_in(cnt_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .done(done), .restart(restart),
    .a_out(a_out), .b_out(b_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // irq_at > 0 raises irq once that many words of this run are written
  task automatic run_op(input logic [7:0] v, input logic [7:0] a, input logic [4:0] c,
                        input bit st, input bit irq0, input int irq_at);
    int t;
    @(negedge clk);
    base = wcnt;
    val_in = v; addr_in = a; cnt_in = c; stall = st; irq = irq0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      if (irq_at > 0 && (wcnt - base) >= irq_at) irq = 1'b1;
      @(negedge clk);
      t++;
    end
    if (t >= 500) check(1'b0, "R4", "run timed out", t, 0);
    nw = wcnt - base;
    irq = 1'b0;
    stall = 1'b0;
  endtask

  task automatic check_words(input string req, input logic [7:0] v,
                             input logic [7:0] a, input int n);
    int bad = -1;
    for (int i = 0; i < n; i++) begin
      if (log_d[(base + i) % 256] !== DW'(v + i) ||
          log_a[(base + i) % 256] !== AW'(a[AW-1:0] + i))
        if (bad < 0) bad = i;
    end
    if (bad < 0) check(1'b1, req, "word contents", 0, 0);
    else check(1'b0, req, "word index with wrong addr/data", bad, -1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(mem_we == 1'b0, "R9", "mem_we after reset", int'(mem_we), 0);
    check(done == 1'b0, "R9", "done after reset", int'(done), 0);
    check(restart == 1'b0, "R9", "restart after reset", int'(restart), 0);
    check(a_out == '0, "R9", "a_out after reset", int'(a_out), 0);
    check(b_out == '0, "R9", "b_out after reset", int'(b_out), 0);

    // R2 R3 R4 R5 R6: table of normal runs
    for (int k = 0; k < NV; k++) begin
      logic [7:0] v, a;
      logic [4:0] c;
      int n;
      v = VEC[k][21:14]; a = VEC[k][13:6]; c = VEC[k][5:1];
      n = (c == 0) ? FULL : int'(c);
      run_op(v, a, c, VEC[k][0], 1'b0, 0);
      check(nw == n, "R4", "write count", nw, n);
      check_words("R3", v, a, n);
      check(restart == 1'b0, "R6", "restart on finish", int'(restart), 0);
      check(a_out == '0, "R6", "a_out on finish", int'(a_out), 0);
      check(b_out == DW'(AW'(a[AW-1:0] + n)), "R6", "b_out on finish",
            int'(b_out), int'(AW'(a[AW-1:0] + n)));
      @(negedge clk);
      check(done == 1'b0, "R6", "done one cycle", int'(done), 0);
    end

    // R1: start pulsed mid-run is ignored
    @(negedge clk);
    base = wcnt;
    val_in = 8'h40; addr_in = 8'h20; cnt_in = 5'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    val_in = 8'h99; addr_in = 8'h01; cnt_in = 5'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 50 && !done; t++) @(negedge clk);
    nw = wcnt - base;
    check(nw == 6, "R1", "writes with start during run", nw, 6);
    check_words("R1", 8'h40, 8'h20, 6);
    check(b_out == 8'h26, "R1", "b_out with start during run", int'(b_out), 8'h26);

    // R7 R8: irq pending before the first write; upper address bits restored
    run_op(8'h70, 8'hC9, 5'd5, 1'b0, 1'b1, 0);
    check(nw == 1, "R8", "one word before irq", nw, 1);
    check_words("R2", 8'h70, 8'hC9, 1);
    check(restart == 1'b1, "R7", "restart on irq", int'(restart), 1);
    check(a_out == 8'h70, "R7", "a_out restored", int'(a_out), 8'h70);
    check(b_out == 8'hC9, "R7", "b_out restored unmasked", int'(b_out), 8'hC9);

    // R8: irq held while the first write stalls
    run_op(8'h11, 8'h33, 5'd7, 1'b1, 1'b1, 0);
    check(nw == 1, "R8", "stalled first write still done", nw, 1);
    check(restart == 1'b1, "R8", "restart after stalled irq", int'(restart), 1);

    // R7: restart stays high until the next start
    repeat (3) @(negedge clk);
    check(restart == 1'b1, "R7", "restart held while idle", int'(restart), 1);

    // R7: irq raised mid-run
    run_op(8'h30, 8'h2A, 5'd10, 1'b0, 1'b0, 3);
    check(nw == 4, "R7", "words before mid-run stop", nw, 4);
    check_words("R7", 8'h30, 8'h2A, 4);
    check(restart == 1'b1, "R7", "restart mid-run", int'(restart), 1);
    check(a_out == 8'h30, "R7", "a_out mid-run", int'(a_out), 8'h30);
    check(b_out == 8'h2A, "R7", "b_out mid-run", int'(b_out), 8'h2A);

    // R8: irq on the only word completes normally and clears restart
    run_op(8'h08, 8'h1F, 5'd1, 1'b0, 1'b1, 0);
    check(nw == 1, "R8", "single word with irq", nw, 1);
    check(restart == 1'b0, "R8", "no restart on last word", int'(restart), 0);
    check(a_out == '0, "R8", "a_out on last-word irq", int'(a_out), 0);
    check(b_out == 8'h20, "R8", "b_out on last-word irq", int'(b_out), 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule